// File: doc/BRIEF.md
# Priority Interrupt Controller

This block collects interrupt requests from eight peripheral lines and presents at most one of them at a time to a processor. A rising edge on a request line leaves a pending bit behind. Pending bits pass through a mask that software can write. Among the requests that remain enabled, the lowest-numbered one is reported on a single interrupt output.

The processor answers with an active-low acknowledge pulse. The controller then moves the chosen request from pending to in-service, drops its interrupt output, and returns an 8-bit vector. The top five bits of the vector are a programmed base and the low three bits are the request number. A request stays in service until software writes an end-of-interrupt command. Until then it holds back requests of equal or lower priority, while higher-priority requests can still nest above it.

Software reaches the controller through two byte-wide ports. The command port (address 0) takes the end-of-interrupt and arm-base commands and reads back the in-service bits. The data port (address 1) reads and writes the mask, and loads the vector base when arming has taken place.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the in-service bits read 0x00, `intr` is low, `vec_valid` is low and the vector base is zero.
- R2: A low-to-high transition of `irq_in[i]`, seen on two consecutive clock edges, sets pending bit i at the second edge. A line held high produces only one request.
- R3: The mask reads and writes at address 1. A 1 in bit i disables line i, so a masked pending request never raises `intr` (mask 0x7E leaves only lines 0 and 7 enabled).
- R4: When several enabled requests are pending, the one with the lowest index is the one granted.
- R5: An acknowledge is a clock edge where `inta_n` is low, was high at the previous edge, and `intr` is high. After that edge, `vec_valid` is high for exactly one cycle and `vec_out` holds the vector. The granted bit leaves pending and enters in-service, and `intr` drops unless a newly latched higher-priority request is present.
- R6: A command-port write of any value with bit 4 set, other than 0x20, arms base loading. The next data-port write then sets the vector base to that value with its low three bits cleared, leaves the mask unchanged and disarms. The vector equals the base with the request index in bits 2:0 (base 0x20 and line 4 give 0x24).
- R7: While any bit is in service, `intr` is raised only for enabled pending requests whose index is lower than that of the lowest in-service bit.
- R8: Writing 0x20 to the command port clears the lowest-indexed in-service bit. With nothing in service it has no effect, and a command value with bit 4 clear other than 0x20 changes nothing. The in-service bits read back at address 0.
- R9: A falling `inta_n` while `intr` is low changes no state and raises no `vec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Peripheral request lines, rising edge sensitive |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the command port, 1 selects the data port |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | In-service bits at address 0, mask at address 1 |
| inta_n | input | 1 | Active-low acknowledge from the processor |
| intr | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last acknowledged request |
| vec_valid | output | 1 | One-cycle marker that `vec_out` is fresh |

## Verification
The bench builds the block with its default eight lines and 8-bit data, which makes every mask pattern and every vector reachable. A behavioural model runs beside the design and checks `intr`, the readback and the vector on every clock. Directed sequences drive nested service of lines 2, 1 and 6. They also cover the 0x7E mask, a base written with nonzero low bits, an end-of-interrupt with nothing in service, ignored command values, and an acknowledge given while `intr` is low.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NIRQ     = 8;
    localparam int DW       = 8;
    localparam int IDW      = $clog2(NIRQ);
    localparam int INIT_BIT = 4;

    typedef logic [NIRQ-1:0] irq_vec_t;
    typedef logic [DW-1:0]   byte_t;
    typedef logic [IDW-1:0]  irq_id_t;

    localparam byte_t CMD_EOI = 8'h20;

    typedef enum logic {PORT_CMD = 1'b0, PORT_DATA = 1'b1} port_e;

    typedef struct packed {
        logic     fire;
        irq_vec_t onehot;
        irq_id_t  id;
    } grant_t;

    function automatic irq_vec_t lowest_onehot(irq_vec_t v);
        irq_vec_t neg;
        neg = ~v + NIRQ'(1);
        return v & neg;
    endfunction

    // Bits of strictly higher priority than the lowest-indexed set bit.
    function automatic irq_vec_t above_mask(irq_vec_t isr);
        irq_vec_t low;
        low = lowest_onehot(isr);
        if (isr == '0) return '1;
        return low - NIRQ'(1);
    endfunction

    function automatic irq_id_t id_of(irq_vec_t onehot);
        irq_id_t id;
        id = '0;
        for (int i = 0; i < NIRQ; i++)
            if (onehot[i]) id = irq_id_t'(i);
        return id;
    endfunction
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch
    import pic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t irq_in,
    input  irq_vec_t clr,
    output irq_vec_t pending
);
    irq_vec_t prev_q;

    for (genvar i = 0; i < NIRQ; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[i]  <= 1'b0;
                pending[i] <= 1'b0;
            end else begin
                prev_q[i]  <= irq_in[i];
                pending[i] <= (pending[i] & ~clr[i]) | (irq_in[i] & ~prev_q[i]);
            end
        end
    end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import pic_pkg::*;
(
    input  irq_vec_t pending,
    input  irq_vec_t mask,
    input  irq_vec_t isr,
    output logic     any_req,
    output irq_vec_t cand_onehot,
    output irq_id_t  cand_id
);
    irq_vec_t eligible;

    always_comb begin
        eligible    = pending & ~mask & above_mask(isr);
        cand_onehot = lowest_onehot(eligible);
        cand_id     = id_of(cand_onehot);
        any_req     = |eligible;
    end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  port_e    addr,
    input  byte_t    wdata,
    input  grant_t   grant,
    output irq_vec_t mask_q,
    output byte_t    base_q,
    output irq_vec_t isr_q,
    output byte_t    rdata
);
    logic     init_q;
    logic     cmd_wr, data_wr, eoi;
    irq_vec_t isr_clear, isr_set;

    always_comb begin
        cmd_wr    = we && (addr == PORT_CMD);
        data_wr   = we && (addr == PORT_DATA);
        eoi       = cmd_wr && (wdata == CMD_EOI);
        isr_clear = eoi ? lowest_onehot(isr_q) : '0;
        isr_set   = grant.fire ? grant.onehot : '0;
        rdata     = (addr == PORT_DATA) ? byte_t'(mask_q) : byte_t'(isr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            base_q <= '0;
            isr_q  <= '0;
            init_q <= 1'b0;
        end else begin
            isr_q <= (isr_q & ~isr_clear) | isr_set;
            if (cmd_wr && !eoi && wdata[INIT_BIT])
                init_q <= 1'b1;
            if (data_wr) begin
                if (init_q) begin
                    base_q <= {wdata[DW-1:IDW], IDW'(0)};
                    init_q <= 1'b0;
                end else begin
                    mask_q <= irq_vec_t'(wdata);
                end
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] irq_in,
    input  logic       reg_we,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       inta_n,
    output logic       intr,
    output logic [7:0] vec_out,
    output logic       vec_valid
);
    irq_vec_t pending_q, mask_q, isr_q, cand_onehot;
    irq_id_t  cand_id;
    byte_t    base_q;
    logic     any_req, inta_prev_n;
    grant_t   grant;

    pic_req_latch u_latch (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .clr(grant.fire ? grant.onehot : irq_vec_t'(0)),
        .pending(pending_q)
    );

    pic_resolver u_res (
        .pending(pending_q), .mask(mask_q), .isr(isr_q),
        .any_req(any_req), .cand_onehot(cand_onehot), .cand_id(cand_id)
    );

    always_comb begin
        grant.fire   = !inta_n && inta_prev_n && any_req;
        grant.onehot = cand_onehot;
        grant.id     = cand_id;
        intr         = any_req;
    end

    pic_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(port_e'(reg_addr)),
        .wdata(reg_wdata), .grant(grant),
        .mask_q(mask_q), .base_q(base_q), .isr_q(isr_q), .rdata(reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            inta_prev_n <= 1'b1;
            vec_valid   <= 1'b0;
            vec_out     <= '0;
        end else begin
            inta_prev_n <= inta_n;
            vec_valid   <= grant.fire;
            if (grant.fire)
                vec_out <= {base_q[DW-1:IDW], grant.id};
        end
    end
endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     intr,
    input logic     vec_valid,
    input byte_t    vec_out,
    input irq_vec_t pending,
    input irq_vec_t mask,
    input irq_vec_t isr,
    input byte_t    base,
    input logic     reg_we,
    input logic     reg_addr,
    input byte_t    reg_wdata,
    input logic     ack_fire,
    input irq_vec_t ack_onehot
);
    AST_MASKED_NO_INTR: assert property (@(posedge clk) disable iff (rst)
        intr |-> ((pending & ~mask) != '0)); // R3

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        ack_fire |-> ($countones(ack_onehot) == 1)); // R4

    AST_VALID_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> isr[vec_out[IDW-1:0]]); // R5

    AST_VEC_BASE: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_out[DW-1:IDW] == $past(base[DW-1:IDW]))); // R6

    AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_addr && reg_wdata == CMD_EOI && isr != '0 && !ack_fire)
        |=> ($countones(isr) == $countones($past(isr)) - 1)); // R8

    AST_NO_VALID_WITHOUT_INTR: assert property (@(posedge clk) disable iff (rst)
        !intr |=> !vec_valid); // R9
endmodule

bind prio_irq_ctrl pic_checker u_chk (
    .clk(clk), .rst(rst), .intr(intr), .vec_valid(vec_valid), .vec_out(vec_out),
    .pending(pending_q), .mask(mask_q), .isr(isr_q), .base(base_q),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ack_fire(grant.fire), .ack_onehot(grant.onehot)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       inta_n = 1'b1;
    logic       intr, vec_valid;
    logic [7:0] vec_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .inta_n(inta_n),
        .intr(intr), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    // Behavioural reference model
    logic [7:0] m_pend, m_mask, m_isr, m_base, m_iprev, m_vec;
    logic       m_init, m_aprev, m_vv;

    function automatic int m_pick();
        int hi = 8;
        for (int i = 7; i >= 0; i--) if (m_isr[i]) hi = i;
        for (int i = 0; i < hi; i++) if (m_pend[i] && !m_mask[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_mask = 8'hFF; m_isr = 0; m_base = 0; m_iprev = 0;
            m_vec = 0; m_init = 0; m_aprev = 1; m_vv = 0;
        end else begin
            int w;
            logic [7:0] rise, clrb, setb;
            w = m_pick();
            rise = irq_in & ~m_iprev;
            clrb = 0; setb = 0;
            m_vv = 0;
            if (!inta_n && m_aprev && w >= 0) begin
                setb = 8'd1 << w;
                m_vv = 1;
                m_vec = (m_base & 8'hF8) + 8'(w);
            end
            if (reg_we && !reg_addr) begin
                if (reg_wdata == 8'h20) begin
                    for (int i = 7; i >= 0; i--) if (m_isr[i]) clrb = 8'd1 << i;
                end else if (reg_wdata[4]) m_init = 1;
            end
            if (reg_we && reg_addr) begin
                if (m_init) begin m_base = reg_wdata & 8'hF8; m_init = 0; end
                else m_mask = reg_wdata;
            end
            m_isr  = (m_isr & ~clrb) | setb;
            m_pend = (m_pend & ~setb) | rise;
            m_iprev = irq_in;
            m_aprev = inta_n;
        end
    end

    // Continuous comparison one time step after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            n_cmp++;
            if (intr !== (m_pick() >= 0)) begin
                n_bad++;
                $display("FAIL R7 intr: actual %0b expected %0b", intr, m_pick() >= 0);
            end
            n_cmp++;
            if (reg_rdata !== (reg_addr ? m_mask : m_isr)) begin
                n_bad++;
                $display("FAIL R8 readback: actual %02h expected %02h", reg_rdata,
                         reg_addr ? m_mask : m_isr);
            end
            n_cmp++;
            if (vec_valid !== m_vv || (m_vv && vec_out !== m_vec)) begin
                n_bad++;
                $display("FAIL R5 vector: actual %0b/%02h expected %0b/%02h",
                         vec_valid, vec_out, m_vv, m_vec);
            end
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(logic a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic pulse(logic [7:0] bits);
        irq_in = bits; @(negedge clk);
        irq_in = 0;    @(negedge clk);
    endtask

    task automatic ack();
        inta_n = 0; @(negedge clk);
        inta_n = 1;
    endtask

    logic [7:0] r;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        rd(1, r); chk("R1 mask after reset", r, 8'hFF);
        rd(0, r); chk("R1 isr after reset", r, 8'h00);
        chk("R1 intr after reset", {7'd0, intr}, 8'h00);
        chk("R1 vec_valid after reset", {7'd0, vec_valid}, 8'h00);

        // R6: arm and load base 0x20 (low bits discarded)
        wr(0, 8'h13); wr(1, 8'h27);
        rd(1, r); chk("R6 mask untouched by base load", r, 8'hFF);

        // R2/R3: masked request stays silent, then unmask
        pulse(8'h10);
        chk("R3 masked request keeps intr low", {7'd0, intr}, 8'h00);
        wr(1, 8'hEF); #1;
        chk("R2 latched request raises intr", {7'd0, intr}, 8'h01);
        rd(1, r); chk("R3 mask readback", r, 8'hEF);

        // R5: acknowledge returns 0x24
        ack();
        chk("R5 vec_valid after ack", {7'd0, vec_valid}, 8'h01);
        chk("R6 vector base plus id", vec_out, 8'h24);
        chk("R5 intr drops", {7'd0, intr}, 8'h00);
        @(negedge clk);
        chk("R5 vec_valid one cycle", {7'd0, vec_valid}, 8'h00);
        rd(0, r); chk("R5 in-service bit", r, 8'h10);
        wr(0, 8'h20);
        rd(0, r); chk("R8 eoi clears", r, 8'h00);

        // R3: mask 0x7E, only line 7 of {5,7}
        wr(1, 8'h7E);
        pulse(8'hA0);
        ack();
        chk("R3 only enabled line 7 granted", vec_out, 8'h27);
        wr(0, 8'h20);
        wr(1, 8'h00); #1;
        chk("R3 unmasking releases line 5", {7'd0, intr}, 8'h01);
        ack(); wr(0, 8'h20);

        // R4/R7: lines 6 and 2 together
        pulse(8'h44);
        ack();
        chk("R4 lowest index wins", vec_out, 8'h22);
        chk("R7 lower priority held back", {7'd0, intr}, 8'h00);
        pulse(8'h02); #1;
        chk("R7 higher priority nests", {7'd0, intr}, 8'h01);
        ack();
        chk("R7 nested vector", vec_out, 8'h21);
        rd(0, r); chk("R7 two in service", r, 8'h06);
        wr(0, 8'h20);
        rd(0, r); chk("R8 lowest in-service cleared", r, 8'h04);
        chk("R7 line 6 still held", {7'd0, intr}, 8'h00);
        wr(0, 8'h05);
        rd(0, r); chk("R8 other command ignored", r, 8'h04);
        wr(0, 8'h20); #1;
        chk("R7 line 6 released", {7'd0, intr}, 8'h01);
        ack();
        chk("R4 line 6 vector", vec_out, 8'h26);
        wr(0, 8'h20);
        wr(0, 8'h20);
        rd(0, r); chk("R8 eoi with nothing in service", r, 8'h00);

        // R9: acknowledge without intr
        ack();
        chk("R9 no vector without intr", {7'd0, vec_valid}, 8'h00);
        rd(0, r); chk("R9 isr unchanged", r, 8'h00);

        // R6: base 0xA8 from 0xAF, line 0
        wr(0, 8'h10); wr(1, 8'hAF);
        rd(1, r); chk("R6 mask kept", r, 8'h00);
        pulse(8'h01);
        ack();
        chk("R6 base low bits dropped", vec_out, 8'hA8);
        wr(0, 8'h20);

        // R2: held line gives a single request
        irq_in = 8'h08; repeat (3) @(negedge clk);
        ack(); wr(0, 8'h20); #1;
        chk("R2 held line no repeat", {7'd0, intr}, 8'h00);
        irq_in = 0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule